// File: doc/BRIEF.md
# Block-Cyclic Banked Array Memory

This block holds a two-dimensional array of words spread over several physical banks. It lets a pipelined loop that reads a fixed neighbourhood of the array, such as a four-point stencil, fetch all of its operands in the same cycle. Each of the `NREQ` read requesters presents an (x0, x1) coordinate. The block works out which bank holds that element and where it sits inside the bank, steers the address to that bank's read port, and one cycle later steers the bank's word back to the requester.

An element's bank comes from a linear combination of its coordinates. That sum is divided into blocks of `BLK` consecutive values, and the blocks are dealt round-robin to `NBANK` banks. The row length is padded up to a multiple of `NBANK*BLK`, so every row holds the same number of words in each bank and the intra-bank offset needs only shifts, masks and one constant multiply. A single write port loads the array through the same mapping and also shows the bank and offset it computes.

Each bank has `PORTS` read ports. When more valid requests than that aim at one bank in the same cycle, the lowest-numbered requesters win the ports. The others are dropped and a conflict flag is raised.

Top module: `bcm_array_mem`

## Requirements
- R1: The bank of element (x0, x1) is floor((ALPHA0*x0 + ALPHA1*x1) / BLK) mod NBANK. `BLK` is a power of two. The bank is shown on `wr_bank` for the coordinate on `wr_x0`/`wr_x1` in the same cycle.
- R2: With S = BLK*ceil(W1/(NBANK*BLK)), the intra-bank offset is x0*S + floor(x1/(NBANK*BLK))*BLK + (x1 mod BLK). It is shown on `wr_offset`. With ALPHA=(2,1), NBANK=5 and BLK=1, element (5,5) gives bank 0 and offset 11.
- R3: Each bank is ceil(W0*(W1+pad)/NBANK) words deep, where pad brings W1 up to a multiple of NBANK*BLK. Every offset is below that depth. No two elements of the array share a (bank, offset) pair when ALPHA1 is 1.
- R4: When `wr_en` is high at a clock edge, `wr_data` is stored at the mapped location. A later read of that coordinate returns the most recently written word.
- R5: A granted request in cycle t shows `rsp_valid` high and its data on `rsp_data` in cycle t+1. No response appears without a request.
- R6: With ALPHA=(3,1), NBANK=4, BLK=2 and one port per bank, the four reads (x0,x1-1), (x0-1,x1), (x0+1,x1), (x0,x1+1) are all served in every cycle and `conflict` stays low.
- R7: When more than PORTS valid requests target one bank, the PORTS lowest-indexed of them are served. The rest get `rsp_valid` low, and `conflict` is high in the response cycle.
- R8: With PORTS=2, two requests to the same bank are both served without conflict. A third request to that bank is dropped and raises `conflict`.
- R9: A requester with `req_valid` low gets `rsp_valid` low and `rsp_data` zero, and takes no port from any other requester.
- R10: While `rst_n` is low at a clock edge, `rsp_valid` and `conflict` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NREQ | Read request valid, one bit per requester |
| req_x0 | input | NREQ x X0W | Row coordinate per requester |
| req_x1 | input | NREQ x X1W | Column coordinate per requester |
| wr_en | input | 1 | Write strobe |
| wr_x0 | input | X0W | Write row coordinate |
| wr_x1 | input | X1W | Write column coordinate |
| wr_data | input | DW | Write word |
| rsp_valid | output | NREQ | Read data valid, one cycle after a granted request |
| rsp_data | output | NREQ x DW | Read data per requester, zero when not valid |
| conflict | output | 1 | Some request of the previous cycle exceeded its bank's port budget |
| wr_bank | output | BW | Bank computed for the write coordinate |
| wr_offset | output | AW | Intra-bank offset computed for the write coordinate |

## Verification
The mapping is swept over every coordinate of the array, which shows whether the block arithmetic, the padding stride and the uniqueness of locations all hold. A second instance with five banks and unit blocks checks the odd-bank-count path. Reads use the full four-point stencil over every interior point of a loaded array, so a wrong offset or a misrouted return word shows up as a data mismatch. Crafted patterns then place two or three requests on one bank, with one-port and two-port instances side by side, to separate grant order, dropping and the conflict flag. Masked requesters and an overwrite followed by a read cover the remaining cases.

// File: rtl/bcm_pkg.sv
// Package: shared helpers for the block-cyclic banked array memory.
// Assumes: callers pass positive sizes.
package bcm_pkg;

    // Width of an index that can name n distinct values (at least one bit).
    function automatic int bits_for(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bcm_map.sv
// Module: bcm_map
// Turns one (x0, x1) array coordinate into a bank index and an intra-bank offset.
// The bank is found by linearising the coordinate with the partition coefficients,
// dividing by the block size and taking the result modulo the bank count. The offset
// relies on the last dimension being padded to a multiple of NBANK*BLK.
// Assumes: BLK is a power of two; coefficients are non-negative; coordinates are in range.
module bcm_map #(
    parameter int W1     = 8,
    parameter int NBANK  = 4,
    parameter int BLK    = 2,
    parameter int ALPHA0 = 3,
    parameter int ALPHA1 = 1,
    parameter int X0W    = 3,
    parameter int X1W    = 3,
    parameter int BW     = 2,
    parameter int AW     = 4
) (
    input  logic [X0W-1:0] x0,
    input  logic [X1W-1:0] x1,
    output logic [BW-1:0]  bank,
    output logic [AW-1:0]  offset
);
    localparam int SPAN      = NBANK * BLK;
    localparam int ROWSTRIDE = BLK * ((W1 + SPAN - 1) / SPAN);
    localparam int BSH       = $clog2(BLK);

    logic [31:0] lin;
    logic [31:0] blk_idx;
    logic [31:0] offs;

    // Linear index, block number, bank and padded-row offset.
    always_comb begin
        lin     = 32'(ALPHA0) * 32'(x0) + 32'(ALPHA1) * 32'(x1);
        blk_idx = lin >> BSH;
        bank    = BW'(blk_idx % 32'(NBANK));
        offs    = 32'(x0) * 32'(ROWSTRIDE)
                + (32'(x1) / 32'(SPAN)) * 32'(BLK)
                + (32'(x1) & 32'(BLK - 1));
        offset  = AW'(offs);
    end

endmodule

// File: rtl/bcm_port_alloc.sv
// Module: bcm_port_alloc
// Request-side crossbar. Each requester is ranked among the earlier valid requesters
// aimed at the same bank. The rank picks the bank port it uses, and any rank at or
// beyond PORTS is refused. Each bank port then collects the offset of the one
// requester granted to it.
// Assumes: at most one granted requester per (bank, port), which the ranking guarantees.
module bcm_port_alloc #(
    parameter int NREQ  = 4,
    parameter int NBANK = 4,
    parameter int PORTS = 1,
    parameter int BW    = 2,
    parameter int AW    = 4,
    parameter int PW    = 1
) (
    input  logic [NREQ-1:0]                        req_valid,
    input  logic [NREQ-1:0][BW-1:0]                req_bank,
    input  logic [NREQ-1:0][AW-1:0]                req_off,
    output logic [NREQ-1:0]                        grant,
    output logic [NREQ-1:0][PW-1:0]                port_sel,
    output logic [NBANK-1:0][PORTS-1:0]            rd_en,
    output logic [NBANK-1:0][PORTS-1:0][AW-1:0]    rd_addr,
    output logic                                   over_budget
);
    int rank [NREQ];

    // Rank each requester among lower-indexed valid ones on the same bank.
    always_comb begin
        for (int i = 0; i < NREQ; i++) begin
            rank[i] = 0;
            for (int j = 0; j < i; j++) begin
                if (req_valid[j] && (req_bank[j] == req_bank[i])) begin
                    rank[i] = rank[i] + 1;
                end
            end
            grant[i]    = req_valid[i] && (rank[i] < PORTS);
            port_sel[i] = PW'(rank[i]);
        end
    end

    // A valid requester left without a port marks a budget overrun.
    assign over_budget = |(req_valid & ~grant);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        for (genvar p = 0; p < PORTS; p++) begin : g_port
            logic          en_l;
            logic [AW-1:0] addr_l;

            // Pick the offset of the requester granted to this bank port.
            always_comb begin
                en_l   = 1'b0;
                addr_l = '0;
                for (int i = 0; i < NREQ; i++) begin
                    if (grant[i] && (req_bank[i] == BW'(b)) && (port_sel[i] == PW'(p))) begin
                        en_l   = 1'b1;
                        addr_l = addr_l | req_off[i];
                    end
                end
            end

            assign rd_en[b][p]   = en_l;
            assign rd_addr[b][p] = addr_l;
        end
    end

endmodule

// File: rtl/bcm_bank.sv
// Module: bcm_bank
// One physical bank: a single write port and PORTS registered read ports.
// Assumes: a read and a write to the same word in one cycle return the old word.
module bcm_bank #(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int DW    = 16,
    parameter int PORTS = 1
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [DW-1:0]               wr_data,
    input  logic [PORTS-1:0]            rd_en,
    input  logic [PORTS-1:0][AW-1:0]    rd_addr,
    output logic [PORTS-1:0][DW-1:0]    rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // Store the incoming word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < PORTS; p++) begin : g_rd
        logic [DW-1:0] q;

        // Registered read for this port.
        always_ff @(posedge clk) begin
            if (rd_en[p]) begin
                q <= mem[rd_addr[p]];
            end
        end

        assign rd_data[p] = q;
    end

endmodule

// File: rtl/bcm_array_mem.sv
// Module: bcm_array_mem (top)
// A two-dimensional array spread over NBANK banks with a block-cyclic mapping.
// Each cycle it takes NREQ read coordinates, maps them, allocates bank ports and
// returns the words one cycle later through a per-requester return selector.
// Requests beyond a bank's port budget are dropped and flagged. A write port loads
// the array through the same mapping and shows the bank and offset it computes.
// Assumes: coordinates are inside the W0 x W1 array; BLK is a power of two.
module bcm_array_mem
    import bcm_pkg::*;
#(
    parameter int W0     = 8,
    parameter int W1     = 8,
    parameter int NBANK  = 4,
    parameter int BLK    = 2,
    parameter int ALPHA0 = 3,
    parameter int ALPHA1 = 1,
    parameter int NREQ   = 4,
    parameter int PORTS  = 1,
    parameter int DW     = 16,
    localparam int X0W   = bits_for(W0),
    localparam int X1W   = bits_for(W1),
    localparam int BW    = bits_for(NBANK),
    localparam int SPAN  = NBANK * BLK,
    localparam int PADW  = SPAN * ((W1 + SPAN - 1) / SPAN),
    localparam int DEPTH = (W0 * PADW + NBANK - 1) / NBANK,
    localparam int AW    = bits_for(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NREQ-1:0]              req_valid,
    input  logic [NREQ-1:0][X0W-1:0]     req_x0,
    input  logic [NREQ-1:0][X1W-1:0]     req_x1,
    input  logic                         wr_en,
    input  logic [X0W-1:0]               wr_x0,
    input  logic [X1W-1:0]               wr_x1,
    input  logic [DW-1:0]                wr_data,
    output logic [NREQ-1:0]              rsp_valid,
    output logic [NREQ-1:0][DW-1:0]      rsp_data,
    output logic                         conflict,
    output logic [BW-1:0]                wr_bank,
    output logic [AW-1:0]                wr_offset
);
    localparam int PW = bits_for(PORTS);

    logic [NREQ-1:0][BW-1:0]                req_bank;
    logic [NREQ-1:0][AW-1:0]                req_off;
    logic [NREQ-1:0]                        grant;
    logic [NREQ-1:0][PW-1:0]                port_sel;
    logic [NBANK-1:0][PORTS-1:0]            rd_en;
    logic [NBANK-1:0][PORTS-1:0][AW-1:0]    rd_addr;
    logic [NBANK-1:0][PORTS-1:0][DW-1:0]    bank_rdata;
    logic                                   over_budget;

    logic [NREQ-1:0]                        rsp_valid_q;
    logic [NREQ-1:0][BW-1:0]                sel_bank_q;
    logic [NREQ-1:0][PW-1:0]                sel_port_q;
    logic                                   conflict_q;

    // One mapping unit per read requester.
    for (genvar i = 0; i < NREQ; i++) begin : g_rmap
        bcm_map #(
            .W1(W1), .NBANK(NBANK), .BLK(BLK), .ALPHA0(ALPHA0), .ALPHA1(ALPHA1),
            .X0W(X0W), .X1W(X1W), .BW(BW), .AW(AW)
        ) u_map (
            .x0(req_x0[i]), .x1(req_x1[i]), .bank(req_bank[i]), .offset(req_off[i])
        );
    end

    // Mapping unit for the write port.
    bcm_map #(
        .W1(W1), .NBANK(NBANK), .BLK(BLK), .ALPHA0(ALPHA0), .ALPHA1(ALPHA1),
        .X0W(X0W), .X1W(X1W), .BW(BW), .AW(AW)
    ) u_wmap (
        .x0(wr_x0), .x1(wr_x1), .bank(wr_bank), .offset(wr_offset)
    );

    bcm_port_alloc #(
        .NREQ(NREQ), .NBANK(NBANK), .PORTS(PORTS), .BW(BW), .AW(AW), .PW(PW)
    ) u_alloc (
        .req_valid(req_valid), .req_bank(req_bank), .req_off(req_off),
        .grant(grant), .port_sel(port_sel), .rd_en(rd_en), .rd_addr(rd_addr),
        .over_budget(over_budget)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic we_b;
        assign we_b = wr_en && (wr_bank == BW'(b));

        bcm_bank #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PORTS(PORTS)) u_bank (
            .clk(clk), .wr_en(we_b), .wr_addr(wr_offset), .wr_data(wr_data),
            .rd_en(rd_en[b]), .rd_addr(rd_addr[b]), .rd_data(bank_rdata[b])
        );
    end

    // Hold each requester's grant, bank and port for the cycle its data returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= '0;
            sel_bank_q  <= '0;
            sel_port_q  <= '0;
            conflict_q  <= 1'b0;
        end else begin
            rsp_valid_q <= grant;
            sel_bank_q  <= req_bank;
            sel_port_q  <= port_sel;
            conflict_q  <= over_budget;
        end
    end

    // Return selector: each requester picks the word from its own bank port.
    for (genvar i = 0; i < NREQ; i++) begin : g_ret
        logic [DW-1:0] d;

        always_comb begin
            d = '0;
            if (rsp_valid_q[i]) begin
                for (int b = 0; b < NBANK; b++) begin
                    for (int p = 0; p < PORTS; p++) begin
                        if ((sel_bank_q[i] == BW'(b)) && (sel_port_q[i] == PW'(p))) begin
                            d = bank_rdata[b][p];
                        end
                    end
                end
            end
        end

        assign rsp_data[i] = d;

        // R5: a response only follows a request in the previous cycle.
        a_r5_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_valid[i] |-> $past(req_valid[i]));

        // R3: every mapped offset fits inside the bank depth.
        a_r3_offset_in_depth: assert property (@(posedge clk) disable iff (!rst_n)
            req_valid[i] |-> (32'(req_off[i]) < DEPTH));
    end

    assign rsp_valid = rsp_valid_q;
    assign conflict  = conflict_q;

    // R7: a flagged conflict means fewer responses than requests.
    a_r7_conflict_drops: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |-> ($countones(rsp_valid) < $countones($past(req_valid))));

    // R6: without a conflict every request of the previous cycle is answered.
    a_r6_full_service: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !conflict) |-> (rsp_valid == $past(req_valid)));

endmodule

// File: tb/bcm_array_mem_test.sv
// Scoreboard bench: a driver task queues the expected response of each request
// cycle for two instances (one and two ports per bank); a negedge monitor pops and
// compares them. A third instance with five banks checks the mapping only.
module bcm_array_mem_test;
    localparam int NREQ = 4;
    localparam int DW   = 16;

    logic clk = 1'b0;
    logic rst_n;
    always #4 clk = ~clk;

    logic [NREQ-1:0]          req_valid;
    logic [NREQ-1:0][2:0]     req_x0, req_x1;
    logic                     wr_en;
    logic [2:0]               wr_x0, wr_x1;
    logic [DW-1:0]            wr_data;

    logic [NREQ-1:0]          a_vld, b_vld;
    logic [NREQ-1:0][DW-1:0]  a_dat, b_dat;
    logic                     a_cf, b_cf;
    logic [1:0]               a_wb, b_wb;
    logic [3:0]               a_wo, b_wo;

    logic [2:0]               n_x0, n_x1;
    logic [NREQ-1:0]          n_vld;
    logic [NREQ-1:0][DW-1:0]  n_dat;
    logic                     n_cf;
    logic [2:0]               n_wb;
    logic [3:0]               n_wo;

    bcm_array_mem #(.NBANK(4), .BLK(2), .ALPHA0(3), .ALPHA1(1), .PORTS(1)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_x0(req_x0), .req_x1(req_x1),
        .wr_en(wr_en), .wr_x0(wr_x0), .wr_x1(wr_x1), .wr_data(wr_data),
        .rsp_valid(a_vld), .rsp_data(a_dat), .conflict(a_cf), .wr_bank(a_wb), .wr_offset(a_wo));

    bcm_array_mem #(.NBANK(4), .BLK(2), .ALPHA0(3), .ALPHA1(1), .PORTS(2)) uut_p2 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_x0(req_x0), .req_x1(req_x1),
        .wr_en(wr_en), .wr_x0(wr_x0), .wr_x1(wr_x1), .wr_data(wr_data),
        .rsp_valid(b_vld), .rsp_data(b_dat), .conflict(b_cf), .wr_bank(b_wb), .wr_offset(b_wo));

    bcm_array_mem #(.NBANK(5), .BLK(1), .ALPHA0(2), .ALPHA1(1), .PORTS(1)) uut_n5 (
        .clk(clk), .rst_n(rst_n), .req_valid('0), .req_x0('0), .req_x1('0),
        .wr_en(1'b0), .wr_x0(n_x0), .wr_x1(n_x1), .wr_data('0),
        .rsp_valid(n_vld), .rsp_data(n_dat), .conflict(n_cf), .wr_bank(n_wb), .wr_offset(n_wo));

    typedef struct {
        int                      due;
        logic [NREQ-1:0]         vld;
        logic [NREQ-1:0][DW-1:0] dat;
        logic                    cf;
        string                   tag;
    } exp_t;

    exp_t     qa[$];
    exp_t     qb[$];
    int       checks = 0;
    int       errors = 0;
    int       cyc    = 0;
    logic [DW-1:0] ref_mem [64];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input longint got, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic int ref_bank(int x0, int x1, int a0, int a1, int n, int b);
        return ((a0 * x0 + a1 * x1) / b) % n;
    endfunction

    function automatic int ref_off(int x0, int x1, int n, int b, int w1);
        int stride;
        stride = b * ((w1 + n * b - 1) / (n * b));
        return x0 * stride + (x1 / (n * b)) * b + (x1 % b);
    endfunction

    function automatic logic [DW-1:0] pattern(int x0, int x1, int salt);
        return DW'(((x0 << 8) | x1) ^ 16'hA5C3 ^ salt);
    endfunction

    // Expected grants: lowest-indexed requesters first, up to the port budget (R7, R9).
    function automatic logic [NREQ-1:0] model_grant(logic [NREQ-1:0] v, int bk[NREQ], int ports);
        logic [NREQ-1:0] g;
        g = '0;
        for (int i = 0; i < NREQ; i++) begin
            int r;
            r = 0;
            for (int j = 0; j < i; j++) if (v[j] && bk[j] == bk[i]) r++;
            g[i] = v[i] && (r < ports);
        end
        return g;
    endfunction

    // Driver: present one request cycle and queue the expected results of both instances.
    task automatic issue(input logic [NREQ-1:0] v, input int ax0[NREQ], input int ax1[NREQ],
                         input string tag);
        int   bk[NREQ];
        exp_t ea, eb;
        for (int i = 0; i < NREQ; i++) bk[i] = ref_bank(ax0[i], ax1[i], 3, 1, 4, 2);
        ea.due = cyc + 1; eb.due = cyc + 1;
        ea.tag = tag;     eb.tag = tag;
        ea.vld = model_grant(v, bk, 1);
        eb.vld = model_grant(v, bk, 2);
        ea.cf  = (ea.vld != v);
        eb.cf  = (eb.vld != v);
        for (int i = 0; i < NREQ; i++) begin
            ea.dat[i] = ea.vld[i] ? ref_mem[ax0[i] * 8 + ax1[i]] : '0;
            eb.dat[i] = eb.vld[i] ? ref_mem[ax0[i] * 8 + ax1[i]] : '0;
            req_x0[i] = 3'(ax0[i]);
            req_x1[i] = 3'(ax1[i]);
        end
        req_valid = v;
        qa.push_back(ea);
        qb.push_back(eb);
        @(negedge clk);
    endtask

    task automatic write_elem(input int x0, input int x1, input logic [DW-1:0] d);
        wr_x0 = 3'(x0); wr_x1 = 3'(x1); wr_data = d; wr_en = 1'b1;
        ref_mem[x0 * 8 + x1] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Monitor: compare each instance's response in the cycle it is due.
    always @(negedge clk) begin
        while (qa.size() > 0 && qa[0].due == cyc) begin
            check(a_vld == qa[0].vld, qa[0].tag, "uut rsp_valid", a_vld, qa[0].vld);
            check(a_cf  == qa[0].cf,  qa[0].tag, "uut conflict",  a_cf,  qa[0].cf);
            check(a_dat == qa[0].dat, qa[0].tag, "uut rsp_data",  a_dat, qa[0].dat);
            void'(qa.pop_front());
        end
        while (qb.size() > 0 && qb[0].due == cyc) begin
            check(b_vld == qb[0].vld, qb[0].tag, "uut_p2 rsp_valid", b_vld, qb[0].vld);
            check(b_cf  == qb[0].cf,  qb[0].tag, "uut_p2 conflict",  b_cf,  qb[0].cf);
            check(b_dat == qb[0].dat, qb[0].tag, "uut_p2 rsp_data",  b_dat, qb[0].dat);
            void'(qb.pop_front());
        end
    end

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit used [64];
        rst_n = 1'b0; req_valid = '0; req_x0 = '0; req_x1 = '0;
        wr_en = 1'b0; wr_x0 = '0; wr_x1 = '0; wr_data = '0; n_x0 = '0; n_x1 = '0;
        for (int k = 0; k < 64; k++) begin ref_mem[k] = '0; used[k] = 1'b0; end
        repeat (3) @(negedge clk);

        // R10: outputs cleared while reset is held.
        check(a_vld == '0 && b_vld == '0, "R10", "rsp_valid in reset", {a_vld, b_vld}, 0);
        check(!a_cf && !b_cf, "R10", "conflict in reset", {a_cf, b_cf}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1, R2, R3: mapping over the whole array, offsets in depth and unique.
        for (int x0 = 0; x0 < 8; x0++) begin
            for (int x1 = 0; x1 < 8; x1++) begin
                int eb, eo;
                wr_x0 = 3'(x0); wr_x1 = 3'(x1);
                #1;
                eb = ref_bank(x0, x1, 3, 1, 4, 2);
                eo = ref_off(x0, x1, 4, 2, 8);
                check(int'(a_wb) == eb, "R1", "bank", a_wb, eb);
                check(int'(a_wo) == eo, "R2", "offset", a_wo, eo);
                check(int'(a_wo) < 16 && !used[int'(a_wb) * 16 + int'(a_wo)],
                      "R3", "location unique and in depth", {a_wb, a_wo}, eb * 16 + eo);
                used[int'(a_wb) * 16 + int'(a_wo)] = 1'b1;
            end
        end

        // R2: five banks, unit blocks, coefficients (2,1): (5,5) -> bank 0, offset 11.
        n_x0 = 3'd5; n_x1 = 3'd5;
        #1;
        check(n_wb == 3'd0, "R2", "n5 bank of (5,5)", n_wb, 0);
        check(n_wo == 4'd11, "R2", "n5 offset of (5,5)", n_wo, 11);
        n_x0 = 3'd0; n_x1 = 3'd7;
        #1;
        check(n_wb == 3'd2, "R1", "n5 bank of (0,7)", n_wb, 2);
        check(n_wo == 4'd1, "R2", "n5 offset of (0,7)", n_wo, 1);
        @(negedge clk);

        // R4: load the whole array through the write port.
        for (int x0 = 0; x0 < 8; x0++)
            for (int x1 = 0; x1 < 8; x1++)
                write_elem(x0, x1, pattern(x0, x1, 0));

        // R6, R5, R4: four-point stencil over every interior point.
        for (int x0 = 1; x0 < 7; x0++)
            for (int x1 = 1; x1 < 7; x1++)
                issue(4'hF, '{x0, x0 - 1, x0 + 1, x0}, '{x1 - 1, x1, x1, x1 + 1}, "R6 stencil");

        // R7, R8: (0,0),(0,1) share bank 0; (0,2),(0,3) share bank 1.
        issue(4'hF, '{0, 0, 0, 0}, '{0, 1, 2, 3}, "R7 R8 pairs");
        // R7, R8: three requests on bank 0, fourth masked.
        issue(4'h7, '{0, 0, 2, 0}, '{0, 1, 2, 5}, "R7 R8 triple");

        // R9: masked requester on the same bank takes no port.
        issue(4'h2, '{0, 0, 5, 5}, '{0, 1, 5, 5}, "R9 masked");
        issue(4'h0, '{0, 0, 0, 0}, '{0, 0, 0, 0}, "R9 idle");

        // R4: overwrite then read back.
        write_elem(3, 4, pattern(3, 4, 16'h0F0F));
        issue(4'h1, '{3, 0, 0, 0}, '{4, 0, 0, 0}, "R4 overwrite");
        issue(4'h0, '{0, 0, 0, 0}, '{0, 0, 0, 0}, "R9 idle");
        repeat (3) @(negedge clk);

        check(qa.size() == 0 && qb.size() == 0, "R5", "scoreboard drained",
              qa.size() + qb.size(), 0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule